// File: doc/BRIEF.md
# Supply-Loss Bus Guard

This block sits between a host bus and a battery-backed memory. It turns a low-supply flag into the controls that protect that memory. An external comparator drives the flag high while the supply is below the deselect threshold. The block then gates the memory write strobe, turns off the data output drivers, and drives a warning interrupt line. The interrupt is open-drain style, so it appears as a pull-low enable: 1 pulls the line low and 0 releases it.

When the supply drops, the warning interrupt goes active in the cycle the synchronised flag is first seen. The bus keeps working for a fixed warning window, so the host can finish what it is doing. After that window the memory is write-protected and its outputs are forced to high impedance. When the supply returns, the interrupt is released after a short interval. Protection stays on for a longer recovery interval, and only then is the bus handed back. Every interval is a parameter in microseconds, converted into cycles of the free-running reference clock.

Top module: `pfd_guard`

## Requirements
- R1: The supply flag passes through a two-flop synchroniser. `irq_pull_o` is 1 in every cycle in which the synchronised flag is 1, so it first shows 1 two clock edges after `supply_low_i` rises.
- R2: `wprot_o` and `hiz_o` rise exactly DESEL_CYC cycles after `irq_pull_o` rises from normal operation. DESEL_CYC is (CLK_HZ/1000)*DESEL_US/1000 and must correspond to between 10 µs and 40 µs.
- R3: While `wprot_o` is 1, `mem_we_o` and `dq_oe_o` are 0 whatever the levels of `bus_cs_i`, `bus_we_i` and `bus_oe_i`, and `hiz_o` equals `wprot_o`.
- R4: After the synchronised flag returns to 0, `wprot_o` stays 1 for RECOV_CYC cycles (derived from RECOV_US), which must be at least 1 ms. It falls on the RECOV_CYC-th edge after the synchronised flag falls.
- R5: After the synchronised flag returns to 0, `irq_pull_o` is released on the IRQ_REL_CYC-th edge (derived from IRQ_REL_US), which must be no more than 120 µs.
- R6: When unprotected, including during the warning window, `mem_we_o` = cs AND we and `dq_oe_o` = cs AND oe AND NOT we.
- R7: During and after reset the block behaves as if power had just returned. `wprot_o`, `hiz_o` and `irq_pull_o` are 1 in reset, and `wprot_o` falls RECOV_CYC-1 edges after reset is released.
- R8: A supply drop during recovery returns the block straight to the deselected state. The interrupt comes back at once, and a full recovery interval is timed again from the next return of the supply.
- R9: A supply dip shorter than the warning window still completes deselection on schedule, followed by a full recovery interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low_i | input | 1 | Comparator flag, 1 while the supply is below threshold (asynchronous) |
| bus_cs_i | input | 1 | Host chip select, active high |
| bus_we_i | input | 1 | Host write strobe, active high |
| bus_oe_i | input | 1 | Host output enable, active high |
| irq_pull_o | output | 1 | Pull-low enable for the open-drain warning interrupt |
| wprot_o | output | 1 | Write protect / deselect |
| hiz_o | output | 1 | Forces the memory data outputs to high impedance |
| mem_we_o | output | 1 | Gated write strobe to the memory |
| dq_oe_o | output | 1 | Gated data output drive enable |

## Verification
The bench builds the guard with CLK_HZ = 2,000,000, DESEL_US = 20, RECOV_US = 1100 and IRQ_REL_US = 60. This gives a 40-cycle warning window, a 2200-cycle recovery and a 120-cycle interrupt release. At these sizes, several full power-loss and power-return sequences fit in a short run, each edge can be sampled exactly one cycle before and one cycle on its scheduled boundary, and a drop in the middle of recovery and a dip shorter than the warning window can both be reached.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WARN  = 2'd1,
        ST_DESEL = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_e;

    // Whole cycles of a clock of hz that fit in us microseconds.
    function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
        return (hz / 1000) * us / 1000;
    endfunction

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= async_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfd_seq.sv
module pfd_seq
    import pfd_pkg::*;
#(
    parameter int unsigned DESEL_CYC   = 1000,
    parameter int unsigned RECOV_CYC   = 55000,
    parameter int unsigned IRQ_REL_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_s,
    output logic irq_o,
    output logic prot_o
);
    localparam int CW = $clog2(RECOV_CYC + 1);
    localparam logic [CW-1:0] WARN_LAST  = CW'(DESEL_CYC - 1);
    localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);
    localparam logic [CW-1:0] IRQ_LIMIT  = CW'(IRQ_REL_CYC);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_RUN: begin
                if (low_s) begin
                    nxt_d.st  = ST_WARN;
                    nxt_d.cnt = CW'(1);
                end
            end
            ST_WARN: begin
                if (cur_q.cnt >= WARN_LAST) begin
                    nxt_d.st  = ST_DESEL;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            ST_DESEL: begin
                if (!low_s) begin
                    nxt_d.st  = ST_RECOV;
                    nxt_d.cnt = CW'(1);
                end
            end
            ST_RECOV: begin
                if (low_s) begin
                    nxt_d.st  = ST_DESEL;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt >= RECOV_LAST) begin
                    nxt_d.st  = ST_RUN;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            default: nxt_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= ST_RECOV;
            cur_q.cnt <= CW'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign prot_o = (cur_q.st == ST_DESEL) || (cur_q.st == ST_RECOV);
    assign irq_o  = low_s
                 || (cur_q.st == ST_WARN)
                 || (cur_q.st == ST_DESEL)
                 || ((cur_q.st == ST_RECOV) && (cur_q.cnt < IRQ_LIMIT));

    // R8
    recov_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_RECOV && low_s) |=> (cur_q.st == ST_DESEL && irq_o && prot_o));

endmodule

// File: rtl/pfd_gate.sv
module pfd_gate (
    input  logic prot_i,
    input  logic cs_i,
    input  logic we_i,
    input  logic oe_i,
    output logic mem_we_o,
    output logic dq_oe_o
);
    always_comb begin
        mem_we_o = 1'b0;
        dq_oe_o  = 1'b0;
        if (!prot_i && cs_i) begin
            mem_we_o = we_i;
            dq_oe_o  = oe_i && !we_i;
        end
    end
endmodule

// File: rtl/pfd_guard.sv
module pfd_guard
    import pfd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned DESEL_US    = 20,
    parameter int unsigned RECOV_US    = 1100,
    parameter int unsigned IRQ_REL_US  = 60,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic bus_cs_i,
    input  logic bus_we_i,
    input  logic bus_oe_i,
    output logic irq_pull_o,
    output logic wprot_o,
    output logic hiz_o,
    output logic mem_we_o,
    output logic dq_oe_o
);
    localparam int unsigned DESEL_CYC   = us_to_cyc(CLK_HZ, DESEL_US);
    localparam int unsigned RECOV_CYC   = us_to_cyc(CLK_HZ, RECOV_US);
    localparam int unsigned IRQ_REL_CYC = us_to_cyc(CLK_HZ, IRQ_REL_US);
    localparam int unsigned WARN_MIN    = us_to_cyc(CLK_HZ, 10);
    localparam int unsigned WARN_MAX    = us_to_cyc(CLK_HZ, 40);
    localparam int unsigned REC_MIN     = us_to_cyc(CLK_HZ, 1000);
    localparam int unsigned IRQ_MAX     = us_to_cyc(CLK_HZ, 120);

    logic low_s;
    logic prot;

    pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (supply_low_i),
        .sync_o  (low_s)
    );

    pfd_seq #(
        .DESEL_CYC   (DESEL_CYC),
        .RECOV_CYC   (RECOV_CYC),
        .IRQ_REL_CYC (IRQ_REL_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .low_s  (low_s),
        .irq_o  (irq_pull_o),
        .prot_o (prot)
    );

    pfd_gate u_gate (
        .prot_i   (prot),
        .cs_i     (bus_cs_i),
        .we_i     (bus_we_i),
        .oe_i     (bus_oe_i),
        .mem_we_o (mem_we_o),
        .dq_oe_o  (dq_oe_o)
    );

    assign wprot_o = prot;
    assign hiz_o   = prot;

    // Interval monitors for the timing windows
    logic [31:0] lat_q, rec_q, good_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            rec_q  <= '0;
            good_q <= '0;
        end else begin
            lat_q  <= !irq_pull_o ? '0 : (!prot ? lat_q + 32'd1 : lat_q);
            rec_q  <= low_s ? '0 : (prot ? rec_q + 32'd1 : rec_q);
            good_q <= low_s ? '0 : ((good_q < IRQ_MAX) ? good_q + 32'd1 : good_q);
        end
    end

    // R1
    irq_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_s |-> irq_pull_o);

    // R2
    warn_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wprot_o) |-> (lat_q >= WARN_MIN && lat_q <= WARN_MAX));

    // R3
    bus_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wprot_o |-> (!mem_we_o && !dq_oe_o && hiz_o));

    // R4
    recov_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wprot_o) |-> (rec_q >= REC_MIN));

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_q >= IRQ_MAX && !low_s) |-> !irq_pull_o);

endmodule

// File: tb/sim_pfd_guard.sv
`timescale 1ns/1ps
module sim_pfd_guard;
    localparam int unsigned TB_HZ = 2_000_000;
    localparam int D = (TB_HZ / 1000) * 20 / 1000;    // 40 cycles = 20 us
    localparam int R = (TB_HZ / 1000) * 1100 / 1000;  // 2200 cycles = 1.1 ms
    localparam int I = (TB_HZ / 1000) * 60 / 1000;    // 120 cycles = 60 us

    localparam int ID_IRQ = 0, ID_WP = 1, ID_HIZ = 2, ID_MWE = 3, ID_DQ = 4;

    typedef struct {
        int unsigned at;
        int          id;
        logic        val;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic supply_low, bus_cs, bus_we, bus_oe;
    logic irq_pull, wprot, hiz, mem_we, dq_oe;

    int unsigned cyc = 0;
    int checks = 0;
    int fails = 0;
    exp_t sb[$];
    string nm[5] = '{"irq_pull_o", "wprot_o", "hiz_o", "mem_we_o", "dq_oe_o"};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pfd_guard #(
        .CLK_HZ     (TB_HZ),
        .DESEL_US   (20),
        .RECOV_US   (1100),
        .IRQ_REL_US (60)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low),
        .bus_cs_i     (bus_cs),
        .bus_we_i     (bus_we),
        .bus_oe_i     (bus_oe),
        .irq_pull_o   (irq_pull),
        .wprot_o      (wprot),
        .hiz_o        (hiz),
        .mem_we_o     (mem_we),
        .dq_oe_o      (dq_oe)
    );

    function automatic logic pick(input int id);
        case (id)
            ID_IRQ:  return irq_pull;
            ID_WP:   return wprot;
            ID_HIZ:  return hiz;
            ID_MWE:  return mem_we;
            default: return dq_oe;
        endcase
    endfunction

    // Monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic got;
                got = pick(sb[i].id);
                checks++;
                if (got !== sb[i].val) begin
                    fails++;
                    $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d",
                             sb[i].req, nm[sb[i].id], got, sb[i].val, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int dt, input int id, input logic v, input string rq);
        exp_t e;
        e.at = cyc + dt; e.id = id; e.val = v; e.req = rq;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            fails += sb.size();
            $display("FAIL scoreboard %0d expectations never reached actual=%0d expected=0",
                     sb.size(), sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run hung actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_low = 1'b0;
        bus_cs = 1'b1; bus_we = 1'b1; bus_oe = 1'b0;
        step(2);
        // R7: reset state is protected with the interrupt pulled; R3: strobes blocked
        expect_at(1, ID_WP,  1'b1, "R7");
        expect_at(1, ID_HIZ, 1'b1, "R7");
        expect_at(1, ID_IRQ, 1'b1, "R7");
        expect_at(1, ID_MWE, 1'b0, "R3");
        step(3);
        rst_n = 1'b1;
        // R7: reset behaves like power return
        expect_at(I - 2, ID_IRQ, 1'b1, "R7");
        expect_at(I - 1, ID_IRQ, 1'b0, "R7");
        expect_at(R - 2, ID_WP,  1'b1, "R7");
        expect_at(R - 1, ID_WP,  1'b0, "R7");
        expect_at(R - 1, ID_MWE, 1'b1, "R6");
        step(R + 5);

        // R6: read passes through when unprotected
        bus_we = 1'b0; bus_oe = 1'b1;
        expect_at(1, ID_DQ,  1'b1, "R6");
        expect_at(1, ID_MWE, 1'b0, "R6");
        step(2);
        bus_we = 1'b1; bus_oe = 1'b0;
        step(2);

        // R1/R2: power loss, warning then deselect
        supply_low = 1'b1;
        expect_at(1, ID_IRQ, 1'b0, "R1");
        expect_at(2, ID_IRQ, 1'b1, "R1");
        expect_at(2, ID_MWE, 1'b1, "R6");
        expect_at(D + 1, ID_WP,  1'b0, "R2");
        expect_at(D + 1, ID_MWE, 1'b1, "R6");
        expect_at(D + 2, ID_WP,  1'b1, "R2");
        expect_at(D + 2, ID_HIZ, 1'b1, "R2");
        expect_at(D + 2, ID_MWE, 1'b0, "R3");
        step(D + 10);
        // R3: bus controls ignored while deselected
        bus_we = 1'b0; bus_oe = 1'b1;
        expect_at(1, ID_DQ,  1'b0, "R3");
        expect_at(1, ID_HIZ, 1'b1, "R3");
        step(3);
        bus_we = 1'b1; bus_oe = 1'b0;
        step(1);

        // R4/R5: supply returns
        supply_low = 1'b0;
        expect_at(I + 1, ID_IRQ, 1'b1, "R5");
        expect_at(I + 2, ID_IRQ, 1'b0, "R5");
        expect_at(R + 1, ID_WP,  1'b1, "R4");
        expect_at(R + 1, ID_MWE, 1'b0, "R4");
        expect_at(R + 2, ID_WP,  1'b0, "R4");
        expect_at(R + 2, ID_MWE, 1'b1, "R4");
        step(R + 10);

        // R8: drop again in the middle of recovery
        supply_low = 1'b1;
        step(D + 10);
        supply_low = 1'b0;
        step(300);
        supply_low = 1'b1;
        expect_at(1, ID_IRQ, 1'b0, "R8");
        expect_at(2, ID_IRQ, 1'b1, "R8");
        expect_at(D + 5, ID_WP, 1'b1, "R8");
        step(D + 10);
        supply_low = 1'b0;
        expect_at(R + 1, ID_WP, 1'b1, "R8");
        expect_at(R + 2, ID_WP, 1'b0, "R8");
        step(R + 10);

        // R9: dip shorter than the warning window
        supply_low = 1'b1;
        expect_at(D + 1, ID_WP, 1'b0, "R9");
        expect_at(D + 2, ID_WP, 1'b1, "R9");
        expect_at(D + 1 + R, ID_WP, 1'b1, "R9");
        expect_at(D + 2 + R, ID_WP, 1'b0, "R9");
        step(3);
        supply_low = 1'b0;
        step(D + R + 10);

        finish_run();
    end
endmodule